// File: doc/BRIEF.md
# Staggered Refresh Row-Strobe Sequencer

This block drives four active-low row strobes, one per memory bank, for refresh and for ordinary bank accesses. A refresh is requested by a one-cycle start pulse. The mode input chooses one of two patterns. In all-bank mode every strobe falls on the same clock edge. In staggered mode the strobes fall one bank per edge, which spreads the supply surge over four clocks. The low time of a refresh comes from a 2-bit field. In all-bank mode only, an extend input can stretch that low time.

Accesses use a level request and a bank select. The selected strobe stays low for as long as the request is held. Each bank has its own precharge counter, so a bank that is ready can start while another bank is still precharging, and interleaved access patterns then lose no time. Each bank reports a precharge-done level and a one-cycle refresh-done pulse. A 24-bit refresh row address advances once per completed refresh. In test mode the address is split into a 13-bit counter and an 11-bit counter that both advance.

Top module: `ras_refresh_seq`

## Requirements
- R1: In all-bank mode (`stagger_i`=0 at the accepted start) all four strobes fall on the same edge. That edge is the second rising edge after the cycle in which the start pulse is presented.
- R2: In staggered mode (`stagger_i`=1), bank b falls b cycles after bank 0. Each bank is released after its own low time, so the strobes rise in the same order they fell.
- R3: A refresh keeps each strobe low for `low_cfg_i`+1 cycles, where field values 0..3 give 1..4 cycles.
- R4: In all-bank mode, while `extend_i` is high after the programmed low time, the strobes stay low. They rise on the cycle after the first low cycle in which `extend_i` is low. In staggered mode `extend_i` has no effect.
- R5: After any strobe rises it stays high for at least `pre_cfg_i`+1 cycles, where values 0..3 give 1..4 cycles. `pre_done_o[b]` is 0 from the fall until the last of those high cycles, and 1 in that cycle. An access request waiting on the bank drives the strobe low in the next cycle.
- R6: An access request to a ready bank drives that bank's strobe low in the cycle after the request is presented. The strobe stays low while the request and the select are held. This holds even while another bank is precharging.
- R7: `ref_addr_o` increases by 1 in the cycle after bank 3's refresh-done pulse, and changes at no other time.
- R8: With `test_mode_i`=1, a completed refresh adds 1 to bits [12:0] and adds 1 to bits [23:13], with no carry between the two fields.
- R9: `ref_done_o[b]` is high for exactly one cycle, the first cycle in which bank b's strobe is high after its refresh.
- R10: A start pulse is ignored unless every bank has `pre_done_o` high, no refresh launch is pending and `access_req_i` is low. An ignored start lowers no strobe and does not change `ref_addr_o`.
- R11: After reset, all strobes are high, all `pre_done_o` bits are 1, `ref_done_o` is 0 and `ref_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_start_i | input | 1 | One-cycle request to start a refresh |
| stagger_i | input | 1 | 1: staggered refresh, 0: all banks together |
| extend_i | input | 1 | Stretches the refresh low time in all-bank mode |
| test_mode_i | input | 1 | Splits the refresh address into two counters |
| low_cfg_i | input | 2 | Refresh low time minus one |
| pre_cfg_i | input | 2 | Precharge time minus one |
| access_req_i | input | 1 | Access request level |
| access_bank_i | input | 2 | Bank the access is aimed at |
| ras_n_o | output | 4 | Row strobes, active low, bit b for bank b |
| pre_done_o | output | 4 | Bank precharged and usable |
| ref_done_o | output | 4 | One-cycle pulse when a bank's refresh ends |
| ref_addr_o | output | 24 | Refresh row address |

## Verification
The assertions check properties that must hold in every cycle. Every refresh release comes after at least the latched low time. Every fall of a strobe comes after at least the latched precharge time. All-bank refreshes start together, staggered starts chain bank to bank, and the address moves only after the last bank's done pulse. Other behaviours can only be shown by the bench scenarios, because they depend on exact cycle positions chosen by the stimulus. These are the effect of the extend input in each mode, the exact high-to-low turnaround of an interleaved access, the split counter in test mode, and start pulses being ignored while a request or a precharge is in progress.

// File: rtl/ras_seq_pkg.sv
package ras_seq_pkg;
  typedef enum logic [1:0] {BK_IDLE, BK_ACC, BK_REF, BK_PRE} bank_st_e;
endpackage

// File: rtl/ras_bank.sv
module ras_bank
  import ras_seq_pkg::*;
#(
  parameter int CFG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             acc_i,
  input  logic             ext_i,
  input  logic [CFG_W-1:0] low_cfg_i,
  input  logic [CFG_W-1:0] pre_cfg_i,
  output logic             ras_n_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             in_ref_o
);
  localparam int RUN_W = CFG_W + 1;

  bank_st_e         state_q, state_d;
  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic             fin;

  assign ready_o  = (state_q == BK_IDLE) || (state_q == BK_PRE && cnt_q == '0);
  assign ras_n_o  = !(state_q == BK_ACC || state_q == BK_REF);
  assign in_ref_o = (state_q == BK_REF);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin     = 1'b0;
    if (ready_o) begin
      if (go_i) begin
        state_d = BK_REF;
        cnt_d   = low_cfg_i;
      end else if (acc_i) begin
        state_d = BK_ACC;
      end else begin
        state_d = BK_IDLE;
      end
    end else begin
      case (state_q)
        BK_ACC: if (!acc_i) begin
          state_d = BK_PRE;
          cnt_d   = pre_cfg_i;
        end
        BK_REF: begin
          if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
          else if (!ext_i) begin
            state_d = BK_PRE;
            cnt_d   = pre_cfg_i;
            fin     = 1'b1;
          end
        end
        BK_PRE:  cnt_d = cnt_q - 1'b1;
        default: state_d = BK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BK_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_o  <= fin;
    end
  end

  // run-length monitors for the timing checks
  logic [RUN_W-1:0] lo_run_q, hi_run_q;
  logic [CFG_W-1:0] low_q, pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= '1;
      low_q    <= '0;
      pre_q    <= '0;
    end else begin
      lo_run_q <= ras_n_o ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !ras_n_o ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
      if (state_d == BK_REF && state_q != BK_REF) low_q <= low_cfg_i;
      if (state_d == BK_PRE && state_q != BK_PRE) pre_q <= pre_cfg_i;
    end
  end

  assert_ref_low_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && $past(in_ref_o)) |-> (lo_run_q >= RUN_W'(low_q) + RUN_W'(1)));

  assert_precharge_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_run_q >= RUN_W'(pre_q) + RUN_W'(1)));
endmodule

// File: rtl/ras_ref_launch.sv
module ras_ref_launch #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stagger_i,
  input  logic                 all_ready_i,
  input  logic                 access_i,
  output logic [NUM_BANKS-1:0] go_o,
  output logic [NUM_BANKS-1:0] pend_o,
  output logic                 stag_o
);
  logic accept;
  assign accept = start_i && all_ready_i && !access_i && (pend_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o   <= '0;
      pend_o <= '0;
      stag_o <= 1'b0;
    end else if (accept) begin
      go_o   <= stagger_i ? NUM_BANKS'(1) : '1;
      pend_o <= '1;
      stag_o <= stagger_i;
    end else begin
      go_o   <= stag_o ? (go_o << 1) : '0;
      pend_o <= pend_o & ~go_o;
    end
  end
endmodule

// File: rtl/ras_ref_addr.sv
module ras_ref_addr #(
  parameter int ADDR_W  = 24,
  parameter int SPLIT_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              test_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_d;

  generate
    if (SPLIT_W > 0 && SPLIT_W < ADDR_W) begin : g_split
      always_comb begin
        if (test_i)
          addr_d = {addr_o[ADDR_W-1:SPLIT_W] + 1'b1, addr_o[SPLIT_W-1:0] + 1'b1};
        else
          addr_d = addr_o + 1'b1;
      end
    end else begin : g_flat
      assign addr_d = addr_o + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (inc_i) addr_o <= addr_d;
  end
endmodule

// File: rtl/ras_refresh_seq.sv
module ras_refresh_seq #(
  parameter int NUM_BANKS  = 4,
  parameter int CFG_W      = 2,
  parameter int ADDR_W     = 24,
  parameter int SPLIT_W    = 13,
  localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 refresh_start_i,
  input  logic                 stagger_i,
  input  logic                 extend_i,
  input  logic                 test_mode_i,
  input  logic [CFG_W-1:0]     low_cfg_i,
  input  logic [CFG_W-1:0]     pre_cfg_i,
  input  logic                 access_req_i,
  input  logic [SEL_W-1:0]     access_bank_i,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic [NUM_BANKS-1:0] pre_done_o,
  output logic [NUM_BANKS-1:0] ref_done_o,
  output logic [ADDR_W-1:0]    ref_addr_o
);
  logic [NUM_BANKS-1:0] go, pend, in_ref;
  logic                 stag_q, ext_en;

  assign ext_en = extend_i && !stag_q;  // stretch only when all banks refresh together

  ras_ref_launch #(.NUM_BANKS(NUM_BANKS)) u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (refresh_start_i),
    .stagger_i   (stagger_i),
    .all_ready_i (&pre_done_o),
    .access_i    (access_req_i),
    .go_o        (go),
    .pend_o      (pend),
    .stag_o      (stag_q)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic acc;
      assign acc = access_req_i && (access_bank_i == SEL_W'(b)) && !pend[b];

      ras_bank #(.CFG_W(CFG_W)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (go[b]),
        .acc_i     (acc),
        .ext_i     (ext_en),
        .low_cfg_i (low_cfg_i),
        .pre_cfg_i (pre_cfg_i),
        .ras_n_o   (ras_n_o[b]),
        .ready_o   (pre_done_o[b]),
        .done_o    (ref_done_o[b]),
        .in_ref_o  (in_ref[b])
      );

      if (b > 0) begin : g_order
        assert_stagger_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (stag_q && $rose(in_ref[b])) |-> $past(in_ref[b-1]));
      end
    end
  endgenerate

  ras_ref_addr #(.ADDR_W(ADDR_W), .SPLIT_W(SPLIT_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ref_done_o[NUM_BANKS-1]),
    .test_i (test_mode_i),
    .addr_o (ref_addr_o)
  );

  assert_all_together_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stag_q && $rose(in_ref[0])) |-> (&in_ref));

  assert_addr_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_addr_o) |-> $past(ref_done_o[NUM_BANKS-1]));
endmodule

// File: tb/tb_ras_refresh_seq.sv
`timescale 1ns/1ps
module tb_ras_refresh_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        refresh_start_i = 1'b0, stagger_i = 1'b0, extend_i = 1'b0, test_mode_i = 1'b0;
  logic [1:0]  low_cfg_i = '0, pre_cfg_i = '0, access_bank_i = '0;
  logic        access_req_i = 1'b0;
  logic [3:0]  ras_n_o, pre_done_o, ref_done_o;
  logic [23:0] ref_addr_o;

  int n_chk = 0, n_fail = 0;
  logic [23:0] exp_addr = '0;

  always #2.5 clk_i = ~clk_i;

  ras_refresh_seq dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // refresh: start presented in cycle 0, samples after each later edge
  task automatic run_refresh(input bit stag, input logic [1:0] lcfg, input logic [1:0] pcfg,
                             input bit tmode, input int ext_until, input string req);
    logic [3:0]  ras_r [1:32];
    logic [3:0]  pd_r  [1:32];
    logic [3:0]  dn_r  [1:32];
    logic [23:0] ad_r  [1:32];
    logic [23:0] new_addr;
    int L, r3;
    stagger_i = stag; low_cfg_i = lcfg; pre_cfg_i = pcfg; test_mode_i = tmode;
    for (int t = 0; t < 32; t++) begin
      refresh_start_i = (t == 0);
      extend_i = (t < ext_until);
      step();
      ras_r[t+1] = ras_n_o; pd_r[t+1] = pre_done_o; dn_r[t+1] = ref_done_o; ad_r[t+1] = ref_addr_o;
    end
    refresh_start_i = 0; extend_i = 0;
    L = lcfg + 1;
    if (!stag && ext_until - 1 > L) L = ext_until - 1;
    for (int b = 0; b < 4; b++) begin
      int f, r;
      bit ok_ras, ok_pd, ok_dn;
      logic [31:0] a1, e1;
      f = 2 + (stag ? b : 0);
      r = f + L;
      ok_ras = 1; ok_pd = 1; ok_dn = 1; a1 = 0; e1 = 0;
      for (int t = 1; t <= 32; t++) begin
        bit e_ras, e_pd, e_dn;
        e_ras = !(t >= f && t < r);
        e_pd  = !(t >= f && t < r + pcfg);
        e_dn  = (t == r);
        if (ras_r[t][b] !== e_ras && ok_ras) begin ok_ras = 0; a1 = t; e1 = e_ras; end
        if (pd_r[t][b] !== e_pd) ok_pd = 0;
        if (dn_r[t][b] !== e_dn) ok_dn = 0;
      end
      chk(ok_ras, req, $sformatf("bank%0d strobe window (first bad cycle, exp level)", b), a1, e1);
      chk(ok_pd, "R5", $sformatf("bank%0d precharge-done window", b), {28'd0, pd_r[r][b]}, 0);
      chk(ok_dn, "R9", $sformatf("bank%0d refresh-done pulse", b), {28'd0, dn_r[r][b]}, 1);
    end
    r3 = 2 + (stag ? 3 : 0) + L;
    if (tmode) new_addr = {exp_addr[23:13] + 11'd1, exp_addr[12:0] + 13'd1};
    else       new_addr = exp_addr + 24'd1;
    chk(ad_r[r3] === exp_addr, "R7", "address before completion", ad_r[r3], exp_addr);
    chk(ad_r[r3+1] === new_addr, tmode ? "R8" : "R7", "address after completion", ad_r[r3+1], new_addr);
    exp_addr = new_addr;
    test_mode_i = 0;
  endtask

  task automatic test_reset();
    chk(ras_n_o === 4'hF, "R11", "strobes after reset", ras_n_o, 4'hF);
    chk(pre_done_o === 4'hF, "R11", "precharge-done after reset", pre_done_o, 4'hF);
    chk(ref_done_o === 4'h0, "R11", "refresh-done after reset", ref_done_o, 0);
    chk(ref_addr_o === 24'h0, "R11", "address after reset", ref_addr_o, 0);
  endtask

  task automatic test_interleave();
    pre_cfg_i = 2'd2;
    access_req_i = 1; access_bank_i = 0;
    step();
    chk(ras_n_o === 4'hE, "R6", "bank0 access starts", ras_n_o, 4'hE);
    step(); step();
    access_bank_i = 1;
    step();
    chk(ras_n_o === 4'hD, "R6", "bank1 starts while bank0 precharges", ras_n_o, 4'hD);
    chk(pre_done_o[0] === 1'b0, "R5", "bank0 busy at precharge start", pre_done_o[0], 0);
    access_bank_i = 0;
    step();
    chk(ras_n_o === 4'hF, "R5", "bank0 held high during precharge", ras_n_o, 4'hF);
    step();
    chk(ras_n_o === 4'hF && pre_done_o[0] === 1'b1, "R5", "bank0 last precharge cycle",
        {pre_done_o, ras_n_o}, 8'h1F);
    chk(pre_done_o[1] === 1'b0, "R5", "bank1 still precharging", pre_done_o[1], 0);
    step();
    chk(ras_n_o === 4'hE, "R5", "bank0 re-access right after precharge", ras_n_o, 4'hE);
    chk(pre_done_o[1] === 1'b1, "R5", "bank1 precharged", pre_done_o[1], 1);
    access_req_i = 0;
    wait_idle(6);
  endtask

  task automatic test_ignored_start();
    bit ok;
    pre_cfg_i = 2'd3;
    access_req_i = 1; access_bank_i = 2; refresh_start_i = 1;
    ok = 1;
    for (int t = 1; t <= 6; t++) begin
      step();
      refresh_start_i = 0;
      if (ras_n_o !== 4'hB) ok = 0;
    end
    chk(ok, "R10", "start ignored during access request", ras_n_o, 4'hB);
    access_req_i = 0;
    step();
    refresh_start_i = 1;
    step();
    refresh_start_i = 0;
    chk(pre_done_o[2] === 1'b0, "R10", "bank2 precharging when start arrived", pre_done_o[2], 0);
    ok = 1;
    for (int t = 0; t < 7; t++) begin
      step();
      if (ras_n_o !== 4'hF) ok = 0;
    end
    chk(ok, "R10", "no strobe after start during precharge", ras_n_o, 4'hF);
    chk(ref_addr_o === exp_addr, "R10", "address unchanged", ref_addr_o, exp_addr);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    step();
    test_reset();
    run_refresh(0, 2'd1, 2'd1, 0, 0, "R1");
    run_refresh(1, 2'd2, 2'd0, 0, 0, "R2");
    run_refresh(0, 2'd0, 2'd2, 0, 7, "R4");
    run_refresh(1, 2'd1, 2'd1, 0, 8, "R4");
    run_refresh(0, 2'd3, 2'd3, 0, 0, "R3");
    run_refresh(1, 2'd0, 2'd0, 0, 0, "R3");
    run_refresh(0, 2'd1, 2'd0, 1, 0, "R8");
    test_interleave();
    test_ignored_start();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule